// File: doc/BRIEF.md
# Register File ALU with Result Multiplexer

This block is a datapath slice that pairs a bank of general registers with a small arithmetic unit. Two independent select fields pick the left and right operands from the bank. Four operation circuits work on those two operands at the same time: add, subtract, bitwise AND and unsigned divide. A two-bit operation select then drives a multiplexer that passes one of the four results to the output. A comparator and the carry and borrow signals of the adder and subtractor run alongside and drive flag outputs.

A third select field names the destination register. When write enable is high, the chosen result is written into that register on the rising clock edge. The destination may be either source register or a different one. The surrounding control logic provides the selects and the write enable on every cycle. It reads the result and the flags directly from the ports, with no pipeline stage in between.

Top module: `regalu_core`

## Requirements
- R1: While reset is low, and after it is released, every register holds zero. A register read back by selecting it as both operands with operation AND returns 0.
- R2: The left operand is the register named by `src_a_sel_i` and the right operand is the register named by `src_b_sel_i`. Each select works on its own, and any register may feed either side.
- R3: Operation code 2'b00 gives (a+b) mod 2^W and code 2'b01 gives (a-b) mod 2^W. For every operation code, `carry_o` is the carry out of a+b and `borrow_o` is 1 exactly when a < b.
- R4: Operation code 2'b10 gives a AND b. Operation code 2'b11 gives the truncated unsigned quotient a/b.
- R5: With operation code 2'b11 and a right operand of zero, the result is all ones and `div_zero_o` is 1. `div_zero_o` is 0 in every other case.
- R6: `eq_o`, `lt_o` and `gt_o` report a=b, a<b and a>b for the current operands, and exactly one of them is high.
- R7: On a rising edge with `wr_en_i` high, the register named by `dst_sel_i` takes the current result, and every other register keeps its value. The destination may differ from both sources.
- R8: On a rising edge with `wr_en_i` low, no register changes, whatever the selects and the operation code are.
- R9: When the destination is also a source, the result in that cycle uses the old register value. The written value appears on the operands only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_sel_i | input | 4 | Register index for the left operand |
| src_b_sel_i | input | 4 | Register index for the right operand |
| dst_sel_i | input | 4 | Register index written on write enable |
| op_sel_i | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 divide |
| wr_en_i | input | 1 | Write the result to the destination at the next rising edge |
| result_o | output | 8 | Multiplexed result of the selected operation |
| carry_o | output | 1 | Carry out of the adder |
| borrow_o | output | 1 | Borrow of the subtractor |
| div_zero_o | output | 1 | Divide selected with a zero right operand |
| eq_o | output | 1 | Left operand equals right operand |
| lt_o | output | 1 | Left operand below right operand |
| gt_o | output | 1 | Left operand above right operand |

## Verification
The write-back of a result and the operand read of the same register can happen in the same cycle. The bench provokes this by setting the destination equal to one or both sources, both in directed steps and in a long random run. It judges each such cycle against a behavioural model: the result in that cycle must come from the value held before the edge, and the next cycle must show the new value. Dividing by a zero right operand while writing the all-ones result back into that same zero register is also covered; the model expects the register to hold all ones afterwards.

// File: rtl/regalu_pkg.sv
`timescale 1ns/1ps
package regalu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_AND = 2'b10,
      OP_DIV = 2'b11
   } alu_op_e;

   localparam int OP_COUNT = 4;
   localparam int OP_SEL_W = 2;

endpackage

// File: rtl/regalu_regbank.sv
`timescale 1ns/1ps
module regalu_regbank #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int SEL_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  rd_a_sel_i,
   input  logic [SEL_W-1:0]  rd_b_sel_i,
   input  logic [SEL_W-1:0]  wr_sel_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_a_data_o,
   output logic [DATA_W-1:0] rd_b_data_o
);

   localparam int FULL_DEPTH = 1 << SEL_W;

   generate
      if (NUM_REGS != FULL_DEPTH) begin : g_bad_depth
         $error("regalu_regbank: NUM_REGS must be a power of two matching SEL_W");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("regalu_regbank: DATA_W must be at least 2");
      end
   endgenerate

   logic [NUM_REGS-1:0][DATA_W-1:0] bank_w;

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         logic [DATA_W-1:0] cell_q;
         logic              hit;

         assign hit = wr_en_i && (wr_sel_i == SEL_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cell_q <= '0;
            end else if (hit) begin
               cell_q <= wr_data_i;
            end
         end

         assign bank_w[g] = cell_q;
      end
   endgenerate

   assign rd_a_data_o = bank_w[rd_a_sel_i];
   assign rd_b_data_o = bank_w[rd_b_sel_i];

   // R7: the addressed register holds the written data after the edge
   p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> bank_w[$past(wr_sel_i)] == $past(wr_data_i));

   // R8: without write enable the whole bank is unchanged
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(bank_w));

endmodule

// File: rtl/regalu_opunits.sv
`timescale 1ns/1ps
module regalu_opunits
   import regalu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] sum_o,
   output logic [DATA_W-1:0] diff_o,
   output logic [DATA_W-1:0] and_o,
   output logic [DATA_W-1:0] quot_o,
   output logic              carry_o,
   output logic              borrow_o,
   output logic              div_zero_o,
   output logic              eq_o,
   output logic              lt_o,
   output logic              gt_o
);

   localparam int EXT_W = DATA_W + 1;

   logic [EXT_W-1:0]  sum_ext;
   logic [EXT_W-1:0]  diff_ext;
   logic              b_is_zero;
   logic [DATA_W-1:0] raw_quot;

   // adder and subtractor carry one extra bit for carry and borrow
   assign sum_ext  = {1'b0, a_i} + {1'b0, b_i};
   assign diff_ext = {1'b0, a_i} - {1'b0, b_i};
   assign sum_o    = sum_ext[DATA_W-1:0];
   assign carry_o  = sum_ext[DATA_W];
   assign diff_o   = diff_ext[DATA_W-1:0];
   assign borrow_o = diff_ext[DATA_W];

   assign and_o    = a_i & b_i;

   // combinational truncating divider, saturated on a zero divisor
   assign b_is_zero = (b_i == '0);
   assign raw_quot  = b_is_zero ? '0 : (a_i / b_i);
   assign quot_o    = b_is_zero ? {DATA_W{1'b1}} : raw_quot;
   assign div_zero_o = (op_i == OP_DIV) && b_is_zero;

   // magnitude comparator, separate from the subtractor
   assign eq_o = (a_i == b_i);
   assign lt_o = (a_i <  b_i);
   assign gt_o = (a_i >  b_i);

   // R6: exactly one relation flag is high
   p_one_relation_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({eq_o, lt_o, gt_o}) == 1);

   // R3: subtractor borrow agrees with the comparator
   p_borrow_is_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
      borrow_o == lt_o);

   // R3: a carry means the wrapped sum fell below the left operand
   p_carry_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o == (sum_o < a_i));

endmodule

// File: rtl/regalu_resmux.sv
`timescale 1ns/1ps
module regalu_resmux #(
   parameter int DATA_W     = 8,
   parameter int N_IN       = 4,
   parameter int SEL_W      = 2,
   parameter bit AND_OR_MUX = 1'b1
) (
   input  logic [N_IN-1:0][DATA_W-1:0] cand_i,
   input  logic [SEL_W-1:0]            sel_i,
   output logic [DATA_W-1:0]           y_o
);

   localparam int SEL_SPAN = 1 << SEL_W;

   generate
      if (N_IN > SEL_SPAN) begin : g_bad_sel
         $error("regalu_resmux: SEL_W too narrow for N_IN inputs");
      end

      if (AND_OR_MUX) begin : g_andor
         // decoded select lines gate each input onto a wide OR
         logic [N_IN-1:0] line;
         for (genvar g = 0; g < N_IN; g++) begin : g_line
            assign line[g] = (sel_i == SEL_W'(g));
         end
         always_comb begin
            y_o = '0;
            for (int i = 0; i < N_IN; i++) begin
               y_o = y_o | (cand_i[i] & {DATA_W{line[i]}});
            end
         end
      end else begin : g_index
         always_comb begin
            y_o = '0;
            for (int i = 0; i < N_IN; i++) begin
               if (sel_i == SEL_W'(i)) y_o = cand_i[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/regalu_core.sv
`timescale 1ns/1ps
module regalu_core
   import regalu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_REGS   = 16,
   parameter bit AND_OR_MUX = 1'b1,
   localparam int SEL_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  src_a_sel_i,
   input  logic [SEL_W-1:0]  src_b_sel_i,
   input  logic [SEL_W-1:0]  dst_sel_i,
   input  logic [1:0]        op_sel_i,
   input  logic              wr_en_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              borrow_o,
   output logic              div_zero_o,
   output logic              eq_o,
   output logic              lt_o,
   output logic              gt_o
);

   logic [DATA_W-1:0] opa, opb;
   logic [DATA_W-1:0] sum_w, diff_w, and_w, quot_w;
   logic [OP_COUNT-1:0][DATA_W-1:0] cand;
   alu_op_e op;

   assign op = alu_op_e'(op_sel_i);

   regalu_regbank #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .SEL_W    (SEL_W)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_a_sel_i  (src_a_sel_i),
      .rd_b_sel_i  (src_b_sel_i),
      .wr_sel_i    (dst_sel_i),
      .wr_en_i     (wr_en_i),
      .wr_data_i   (result_o),
      .rd_a_data_o (opa),
      .rd_b_data_o (opb)
   );

   regalu_opunits #(
      .DATA_W (DATA_W)
   ) u_ops (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .a_i        (opa),
      .b_i        (opb),
      .sum_o      (sum_w),
      .diff_o     (diff_w),
      .and_o      (and_w),
      .quot_o     (quot_w),
      .carry_o    (carry_o),
      .borrow_o   (borrow_o),
      .div_zero_o (div_zero_o),
      .eq_o       (eq_o),
      .lt_o       (lt_o),
      .gt_o       (gt_o)
   );

   assign cand[OP_ADD] = sum_w;
   assign cand[OP_SUB] = diff_w;
   assign cand[OP_AND] = and_w;
   assign cand[OP_DIV] = quot_w;

   regalu_resmux #(
      .DATA_W     (DATA_W),
      .N_IN       (OP_COUNT),
      .SEL_W      (OP_SEL_W),
      .AND_OR_MUX (AND_OR_MUX)
   ) u_mux (
      .cand_i (cand),
      .sel_i  (op_sel_i),
      .y_o    (result_o)
   );

   // R5: a zero divisor drives all ones through the result mux
   p_div_zero_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero_o |-> result_o == {DATA_W{1'b1}});

   // R4: an AND result never sets a bit absent from either operand
   p_and_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_AND) |-> ((result_o & ~opa) == '0) && ((result_o & ~opb) == '0));

   // R4: a quotient with a nonzero divisor never exceeds the dividend
   p_quot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DIV && opb != '0) |-> result_o <= opa);

endmodule

// File: tb/regalu_core_tb.sv
`timescale 1ns/1ps
module regalu_core_tb_top;

   localparam int W     = 8;
   localparam int NREG  = 16;
   localparam int MASK  = (1 << W) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a_sel = '0, b_sel = '0, d_sel = '0;
   logic [1:0] op = '0;
   logic       we = 1'b0;
   logic [W-1:0] result;
   logic carry, borrow, dz, eq, lt, gt;

   int n_checks = 0;
   int n_fail   = 0;
   int model [NREG];

   always #2 clk = ~clk;

   regalu_core dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_a_sel_i (a_sel),
      .src_b_sel_i (b_sel),
      .dst_sel_i   (d_sel),
      .op_sel_i    (op),
      .wr_en_i     (we),
      .result_o    (result),
      .carry_o     (carry),
      .borrow_o    (borrow),
      .div_zero_o  (dz),
      .eq_o        (eq),
      .lt_o        (lt),
      .gt_o        (gt)
   );

   task automatic check(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // one cycle: drive, compare combinational outputs, then commit at the edge
   task automatic step(int l, int r, int d, int code, bit wr, string tag);
      int x, y, res, c, bo, z;
      @(negedge clk);
      a_sel = 4'(l); b_sel = 4'(r); d_sel = 4'(d); op = 2'(code); we = wr;
      #1;
      x = model[l];
      y = model[r];
      c  = ((x + y) > MASK) ? 1 : 0;
      bo = (x < y) ? 1 : 0;
      z  = 0;
      case (code)
         0: res = (x + y) & MASK;
         1: res = (x - y) & MASK;
         2: res = x & y;
         default: begin
            if (y == 0) begin res = MASK; z = 1; end
            else res = x / y;
         end
      endcase
      check(tag,  "result", int'(result), res);
      check("R3", "carry",  int'(carry), c);
      check("R3", "borrow", int'(borrow), bo);
      check("R5", "div_zero", int'(dz), z);
      check("R6", "eq", int'(eq), (x == y) ? 1 : 0);
      check("R6", "lt", int'(lt), (x < y) ? 1 : 0);
      check("R6", "gt", int'(gt), (x > y) ? 1 : 0);
      @(posedge clk);
      if (wr) model[d] = res;
   endtask

   task automatic readback(string tag);
      for (int i = 0; i < NREG; i++) step(i, i, 0, 2, 1'b0, tag);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) model[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs during reset with zero registers
      check("R1", "result in reset", int'(result), 0);
      check("R1", "eq in reset", int'(eq), 1);
      @(negedge clk);
      rst_n = 1'b1;
      readback("R1");

      // build values from zero, R5: 0/0 gives all ones
      step(0, 0, 1, 3, 1'b1, "R5");
      step(1, 1, 2, 3, 1'b1, "R4");      // 255/255 = 1
      step(1, 2, 3, 0, 1'b1, "R3");      // 255+1 wraps with carry
      step(2, 2, 3, 0, 1'b1, "R3");      // R3 = 2
      step(1, 3, 4, 1, 1'b1, "R3");      // 253
      step(2, 1, 5, 1, 1'b1, "R3");      // 1-255 wraps with borrow
      step(4, 3, 6, 3, 1'b1, "R4");      // 253/2 = 126 truncated
      step(4, 6, 7, 2, 1'b1, "R4");      // AND
      step(7, 7, 8, 0, 1'b1, "R7");      // destination apart from sources
      readback("R7");

      // R2: swapping the operand selects changes subtract and compare
      step(6, 4, 0, 1, 1'b0, "R2");
      step(4, 6, 0, 1, 1'b0, "R2");
      step(9, 4, 0, 3, 1'b0, "R2");      // 0/253 = 0

      // R8: no write enable, every operation and destination tried
      for (int k = 0; k < 16; k++) step(k, 15 - k, k, k % 4, 1'b0, "R8");
      readback("R8");

      // R9: destination equal to both sources
      step(5, 5, 5, 0, 1'b1, "R9");
      step(5, 5, 0, 2, 1'b0, "R9");
      step(6, 3, 6, 1, 1'b1, "R9");
      step(6, 6, 0, 2, 1'b0, "R9");
      // R5 with write-back into the zero divisor register itself
      step(3, 10, 10, 3, 1'b1, "R5");
      step(10, 10, 0, 2, 1'b0, "R5");

      // random run against the model
      for (int k = 0; k < 600; k++)
         step($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
              $urandom_range(0, 3), 1'($urandom_range(0, 1)), "R7");
      readback("R7");

      summary();
      $finish;
   end

endmodule